// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block is the address translation cache that sits on a coprocessor's memory port. It holds a fully associative set of entries (32 by default). Each entry pairs a tag word with a data word. The tag word carries a virtual page number, a page-size code, a valid flag and a keep flag. The data word carries the physical page number and three attributes: byte order, element size and a mixed-attribute flag. Each entry picks its own page size, one of 16 MB, 1 MB, 64 KB or 4 KB. The page size sets how many upper address bits take part in the tag compare.

Software reaches the block through a small word-wide register port. It writes a tag word and a data word into staging registers, then commits them into the slot that a replacement pointer names. A lock floor keeps the slots below it from being replaced. The same port does the following:
- selects any slot for read-back,
- flushes all entries that are not kept, or only the entry covering one address,
- clears pending fault causes,
- sets the mask that routes causes onto the single interrupt line.

A lookup takes one cycle. It returns either the translated address and attributes, or a fault with the cause recorded and the address captured.

Top module: `vptlb_top`

## Requirements
- R1: After reset, every entry is invalid, the lock floor and replacement pointer are 0, the cause and enable registers are 0, and irq_o is 0. A lookup made right after reset misses.
- R2: A write to address 2 copies the staged tag word and data word into the slot. The valid flag (tag bit 2) is always set on commit, whatever was staged there. Software selects a slot for read-back through the replacement pointer. Address 4 then returns the slot's tag word: bits 31:12 virtual page, bit 3 keep, bit 2 valid, bits 1:0 page-size code, all other bits 0. Address 5 returns its data word: bits 31:12 physical page, bit 9 big-endian, bits 8:7 element size, bit 6 mixed, all other bits 0.
- R3: The page-size code in tag bits 1:0 selects the compare mask: code 0 gives 1 MB (0xFFF00000), code 1 gives 64 KB (0xFFFF0000), code 2 gives 4 KB (0xFFFFF000) and code 3 gives 16 MB (0xFF000000). An address one byte past the page misses.
- R4: A lookup presented with lu_valid_i is answered in the next cycle with lu_done_o high. On a hit, lu_pa_o is the entry's physical page bits under the mask, combined with the virtual address bits outside the mask. No lookup means no lu_done_o.
- R5: On a hit, lu_big_o, lu_esz_o and lu_mixed_o carry the matching entry's attributes. On a fault, lu_pa_o and the attribute outputs are 0.
- R6: A commit writes the slot named by the replacement pointer, or the lock floor if the pointer is below the floor. The pointer then moves to the next slot, and it wraps from the last slot back to the lock floor.
- R7: A write to address 6 clears the valid flag of every entry whose keep flag is 0. Entries with the keep flag set stay valid.
- R8: A write to address 7 clears the valid flag only of the entries whose masked tag matches the written address. Other entries are left unchanged.
- R9: A lookup that matches no valid entry sets cause bit 0 and returns lu_hit_o = 0. Any faulting lookup (a miss or a multi-hit) loads its virtual address into the fault address register at address 10.
- R10: A lookup that matches more than one valid entry sets cause bit 4 and returns lu_hit_o = 0.
- R11: The cause register is at address 8. Writing 1 to a cause bit clears it, and writing 0 leaves it unchanged. A cause raised in the same cycle wins over the clear.
- R12: irq_o is high exactly when some cause bit is pending and its bit in the enable register (address 9, bits 4:0) is set.
- R13: The lock register is at address 3. It holds the lock floor in bits 14:10 and the replacement pointer in bits 8:4, and it reads back in the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| lu_valid_i | input | 1 | Lookup request |
| lu_va_i | input | 32 | Virtual address to translate |
| lu_done_o | output | 1 | Lookup result is valid this cycle |
| lu_hit_o | output | 1 | Exactly one valid entry matched |
| lu_pa_o | output | 32 | Translated physical address |
| lu_big_o | output | 1 | Big-endian attribute of the hit entry |
| lu_esz_o | output | 2 | Element size code of the hit entry |
| lu_mixed_o | output | 1 | Mixed-attribute flag of the hit entry |
| irq_o | output | 1 | OR of the enabled pending causes |

## Verification
A corrupted entry, such as a wrong page-size code, a dropped valid flag or a valid flag that a flush missed, shows up as a wrong lu_hit_o or lu_pa_o on the first lookup into that page. The same fault also shows in the slot's read-back word as soon as software selects the slot. A replacement pointer that steps wrongly shows in the lock register right after the commit. It also shows one lookup later, when a translation lands in the wrong slot or overwrites a locked one. Cause and enable errors show on irq_o in the cycle after the register write or the faulting lookup.

// File: rtl/vptlb_pkg.sv
package vptlb_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_LSB   = 12;
    localparam int PN_W       = ADDR_W - PAGE_LSB;
    localparam int NUM_CAUSE  = 5;
    localparam int CAUSE_MISS = 0;
    localparam int CAUSE_MULT = 4;
    localparam int FLOOR_LSB  = 10;
    localparam int PTR_LSB    = 4;

    // tag word: page number, keep flag, valid flag, page-size code
    typedef struct packed {
        logic [PN_W-1:0] vpn;
        logic            keep;
        logic            valid;
        logic [1:0]      psize;
    } tag_t;

    // data word: physical page and access attributes
    typedef struct packed {
        logic [PN_W-1:0] ppn;
        logic            big;
        logic [1:0]      esz;
        logic            mixed;
    } data_t;

    typedef enum logic [3:0] {
        RA_STG_TAG   = 4'd0,
        RA_STG_DATA  = 4'd1,
        RA_COMMIT    = 4'd2,
        RA_LOCK      = 4'd3,
        RA_RD_TAG    = 4'd4,
        RA_RD_DATA   = 4'd5,
        RA_FLUSH_ALL = 4'd6,
        RA_FLUSH_ONE = 4'd7,
        RA_CAUSE     = 4'd8,
        RA_ENABLE    = 4'd9,
        RA_FAULT_VA  = 4'd10
    } reg_addr_e;

    function automatic logic [ADDR_W-1:0] page_mask(input logic [1:0] psize);
        case (psize)
            2'd0:    page_mask = 32'hFFF0_0000;
            2'd1:    page_mask = 32'hFFFF_0000;
            2'd2:    page_mask = 32'hFFFF_F000;
            default: page_mask = 32'hFF00_0000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] tag_word(input tag_t t);
        tag_word = {t.vpn, 8'b0, t.keep, t.valid, t.psize};
    endfunction

    function automatic logic [ADDR_W-1:0] data_word(input data_t d);
        data_word = {d.ppn, 2'b0, d.big, d.esz, d.mixed, 6'b0};
    endfunction

endpackage

// File: rtl/vptlb_match.sv
module vptlb_match
    import vptlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tag_t [ENTRIES-1:0] tags_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [ENTRIES-1:0] hit_o
);
    // one comparator per entry, mask chosen by that entry's page size
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [ADDR_W-1:0] diff;
        assign diff     = (addr_i ^ {tags_i[i].vpn, {PAGE_LSB{1'b0}}}) & page_mask(tags_i[i].psize);
        assign hit_o[i] = tags_i[i].valid && (diff == '0);
    end
endmodule

// File: rtl/vptlb_select.sv
module vptlb_select
    import vptlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic [ENTRIES-1:0]      hit_i,
    input  logic [ENTRIES-1:0][1:0] psize_i,
    input  data_t [ENTRIES-1:0]     data_i,
    output data_t                   data_o,
    output logic [ADDR_W-1:0]       mask_o,
    output logic                    any_o,
    output logic                    multi_o
);
    // OR-mux: exact on a single hit, flagged as multi otherwise
    always_comb begin
        data_o = '0;
        mask_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_i[i]) begin
                data_o = data_o | data_i[i];
                mask_o = mask_o | page_mask(psize_i[i]);
            end
        end
        any_o   = |hit_i;
        multi_o = |(hit_i & (hit_i - 1'b1));
    end
endmodule

// File: rtl/vptlb_victim.sv
module vptlb_victim #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0] floor_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [IDX_W-1:0] slot_o,
    output logic [IDX_W-1:0] next_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_comb begin
        slot_o = (ptr_i < floor_i) ? floor_i : ptr_i;
        next_o = (slot_o == LAST) ? floor_i : slot_o + 1'b1;
    end
endmodule

// File: rtl/vptlb_top.sv
module vptlb_top
    import vptlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we_i,
    input  logic [3:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic        lu_valid_i,
    input  logic [31:0] lu_va_i,
    output logic        lu_done_o,
    output logic        lu_hit_o,
    output logic [31:0] lu_pa_o,
    output logic        lu_big_o,
    output logic [1:0]  lu_esz_o,
    output logic        lu_mixed_o,
    output logic        irq_o
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        tag_t  [ENTRIES-1:0]  tags;
        data_t [ENTRIES-1:0]  datas;
        logic  [ADDR_W-1:0]   stg_tag;
        logic  [ADDR_W-1:0]   stg_data;
        logic  [IDX_W-1:0]    floor;
        logic  [IDX_W-1:0]    ptr;
        logic  [NUM_CAUSE-1:0] cause;
        logic  [NUM_CAUSE-1:0] enable;
        logic  [ADDR_W-1:0]   fault_va;
        logic                 done;
        logic                 hit;
        logic  [ADDR_W-1:0]   pa;
        logic                 big;
        logic  [1:0]          esz;
        logic                 mixed;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]      lu_hits, fl_hits;
    logic [ENTRIES-1:0][1:0] psize_w;
    data_t                   sel_data;
    logic [ADDR_W-1:0]       sel_mask;
    logic                    sel_any, sel_multi;
    logic [IDX_W-1:0]        commit_slot, ptr_next;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_psz
        assign psize_w[i] = st_q.tags[i].psize;
    end

    vptlb_match #(.ENTRIES(ENTRIES)) u_lu_match (
        .tags_i (st_q.tags),
        .addr_i (lu_va_i),
        .hit_o  (lu_hits)
    );

    vptlb_match #(.ENTRIES(ENTRIES)) u_fl_match (
        .tags_i (st_q.tags),
        .addr_i (reg_wdata_i),
        .hit_o  (fl_hits)
    );

    vptlb_select #(.ENTRIES(ENTRIES)) u_select (
        .hit_i   (lu_hits),
        .psize_i (psize_w),
        .data_i  (st_q.datas),
        .data_o  (sel_data),
        .mask_o  (sel_mask),
        .any_o   (sel_any),
        .multi_o (sel_multi)
    );

    vptlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .floor_i (st_q.floor),
        .ptr_i   (st_q.ptr),
        .slot_o  (commit_slot),
        .next_o  (ptr_next)
    );

    wire wr_commit = reg_we_i && (reg_addr_i == RA_COMMIT);

    always_comb begin
        st_d      = st_q;
        st_d.done = lu_valid_i;

        // register writes
        if (reg_we_i) begin
            case (reg_addr_e'(reg_addr_i))
                RA_STG_TAG:  st_d.stg_tag  = reg_wdata_i;
                RA_STG_DATA: st_d.stg_data = reg_wdata_i;
                RA_COMMIT: begin
                    st_d.tags[commit_slot]  = tag_t'{vpn:   st_q.stg_tag[31:12],
                                                     keep:  st_q.stg_tag[3],
                                                     valid: 1'b1,
                                                     psize: st_q.stg_tag[1:0]};
                    st_d.datas[commit_slot] = data_t'{ppn:   st_q.stg_data[31:12],
                                                      big:   st_q.stg_data[9],
                                                      esz:   st_q.stg_data[8:7],
                                                      mixed: st_q.stg_data[6]};
                    st_d.ptr = ptr_next;
                end
                RA_LOCK: begin
                    st_d.floor = reg_wdata_i[FLOOR_LSB +: IDX_W];
                    st_d.ptr   = reg_wdata_i[PTR_LSB +: IDX_W];
                end
                RA_FLUSH_ALL: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (!st_q.tags[i].keep) st_d.tags[i].valid = 1'b0;
                end
                RA_FLUSH_ONE: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (fl_hits[i]) st_d.tags[i].valid = 1'b0;
                end
                RA_CAUSE:  st_d.cause  = st_q.cause & ~reg_wdata_i[NUM_CAUSE-1:0];
                RA_ENABLE: st_d.enable = reg_wdata_i[NUM_CAUSE-1:0];
                default: ;
            endcase
        end

        // lookup result and fault causes (set wins over clear)
        if (lu_valid_i) begin
            if (sel_any && !sel_multi) begin
                st_d.hit   = 1'b1;
                st_d.pa    = ({sel_data.ppn, {PAGE_LSB{1'b0}}} & sel_mask) | (lu_va_i & ~sel_mask);
                st_d.big   = sel_data.big;
                st_d.esz   = sel_data.esz;
                st_d.mixed = sel_data.mixed;
            end else begin
                st_d.hit      = 1'b0;
                st_d.pa       = '0;
                st_d.big      = 1'b0;
                st_d.esz      = '0;
                st_d.mixed    = 1'b0;
                st_d.fault_va = lu_va_i;
                if (sel_multi) st_d.cause[CAUSE_MULT] = 1'b1;
                else           st_d.cause[CAUSE_MISS] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_e'(reg_addr_i))
            RA_STG_TAG:  reg_rdata_o = st_q.stg_tag;
            RA_STG_DATA: reg_rdata_o = st_q.stg_data;
            RA_LOCK: begin
                reg_rdata_o[FLOOR_LSB +: IDX_W] = st_q.floor;
                reg_rdata_o[PTR_LSB +: IDX_W]   = st_q.ptr;
            end
            RA_RD_TAG:   reg_rdata_o = tag_word(st_q.tags[st_q.ptr]);
            RA_RD_DATA:  reg_rdata_o = data_word(st_q.datas[st_q.ptr]);
            RA_CAUSE:    reg_rdata_o[NUM_CAUSE-1:0] = st_q.cause;
            RA_ENABLE:   reg_rdata_o[NUM_CAUSE-1:0] = st_q.enable;
            RA_FAULT_VA: reg_rdata_o = st_q.fault_va;
            default: ;
        endcase
    end

    assign lu_done_o  = st_q.done;
    assign lu_hit_o   = st_q.hit;
    assign lu_pa_o    = st_q.pa;
    assign lu_big_o   = st_q.big;
    assign lu_esz_o   = st_q.esz;
    assign lu_mixed_o = st_q.mixed;
    assign irq_o      = |(st_q.cause & st_q.enable);

    // R6: after a commit the pointer never sits below the lock floor
    a_r6_ptr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (st_q.ptr >= st_q.floor));

    // R2: the slot just written is valid
    a_r2_commit_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> st_q.tags[$past(commit_slot)].valid);

    // R4: one-cycle answer, and none without a request
    a_r4_answer: assert property (@(posedge clk) disable iff (!rst_n)
        lu_valid_i |=> lu_done_o);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lu_valid_i |=> !lu_done_o);

    // R9 / R10: a failed lookup leaves a cause pending
    a_r9_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_done_o && !lu_hit_o) |-> (st_q.cause[CAUSE_MISS] || st_q.cause[CAUSE_MULT]));

    // R12: nothing enabled, no interrupt
    a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.enable == '0) |-> !irq_o);

endmodule

// File: tb/vptlb_top_tb.sv
module vptlb_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lu_valid = 1'b0;
    logic [31:0] lu_va = '0;
    logic        lu_done, lu_hit, lu_big, lu_mixed, irq;
    logic [31:0] lu_pa;
    logic [1:0]  lu_esz;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic        big;
        logic [1:0]  esz;
        logic        mixed;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    vptlb_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .lu_valid_i(lu_valid), .lu_va_i(lu_va),
        .lu_done_o(lu_done), .lu_hit_o(lu_hit), .lu_pa_o(lu_pa),
        .lu_big_o(lu_big), .lu_esz_o(lu_esz), .lu_mixed_o(lu_mixed), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per answered lookup
    always @(negedge clk) begin
        if (rst_n && lu_done) begin
            if (sb.size() == 0) begin
                chk("R4 unexpected answer", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.req, " hit"},   {31'b0, lu_hit},   {31'b0, e.hit});
                chk({e.req, " pa"},    lu_pa,             e.pa);
                chk({e.req, " attr"},  {28'b0, lu_big, lu_esz, lu_mixed},
                                       {28'b0, e.big, e.esz, e.mixed});
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rdchk(input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic put(input logic [31:0] t, input logic [31:0] d);
        wr(4'd0, t);
        wr(4'd1, d);
        wr(4'd2, 32'h0);
    endtask

    task automatic slotchk(input int idx, input int floor, input logic [31:0] et,
                           input logic [31:0] ed, input string req);
        wr(4'd3, (32'(floor) << 10) | (32'(idx) << 4));
        rdchk(4'd4, et, {req, " tag"});
        rdchk(4'd5, ed, {req, " data"});
    endtask

    // driver: pushes the expected answer and issues the lookup
    task automatic look(input logic [31:0] va, input logic hit, input logic [31:0] pa,
                        input logic big, input logic [1:0] esz, input logic mixed,
                        input string req);
        exp_t e;
        e.hit = hit; e.pa = pa; e.big = big; e.esz = esz; e.mixed = mixed; e.req = req;
        @(negedge clk);
        sb.push_back(e);
        lu_valid = 1'b1; lu_va = va;
        @(negedge clk);
        lu_valid = 1'b0;
    endtask

    task automatic miss(input logic [31:0] va, input string req);
        look(va, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, req);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk(4'd3, 32'h0, "R1 lock");
        rdchk(4'd8, 32'h0, "R1 cause");
        rdchk(4'd4, 32'h0, "R1 slot0 tag");
        chk("R1 irq", {31'b0, irq}, 32'h0);
        miss(32'h1234_5678, "R1 lookup after reset");
        settle();
        rdchk(4'd10, 32'h1234_5678, "R9 fault address");
        rdchk(4'd8, 32'h1, "R9 miss cause");
        wr(4'd8, 32'h1);
        rdchk(4'd8, 32'h0, "R11 w1c");

        // fill slots 0..4
        put(32'h0040_0002, 32'h8000_1340);   // 4KB, valid bit staged 0
        rdchk(4'd3, 32'h10, "R6 pointer advanced");
        put(32'h1000_0FF0, 32'h2005_5CBF);   // 1MB, junk in unused bits
        put(32'h3001_0001, 32'h4ABC_0180);   // 64KB, esz 3
        put(32'h5500_000B, 32'h6612_3000);   // 16MB, keep
        put(32'h5500_1002, 32'h7777_7000);   // 4KB inside the 16MB page
        slotchk(0, 0, 32'h0040_0006, 32'h8000_1340, "R2 slot0");
        slotchk(1, 0, 32'h1000_0004, 32'h2005_5080, "R2 slot1");
        slotchk(3, 0, 32'h5500_000F, 32'h6612_3000, "R2 slot3");
        wr(4'd3, 32'h50);
        rdchk(4'd3, 32'h50, "R13 lock readback");

        // translations per page size
        look(32'h0040_0ABC, 1'b1, 32'h8000_1ABC, 1'b1, 2'd2, 1'b1, "R5 4KB attrs");
        miss(32'h0040_1000, "R3 4KB boundary");
        look(32'h100F_FFFC, 1'b1, 32'h200F_FFFC, 1'b0, 2'd1, 1'b0, "R4 1MB pa");
        look(32'h3001_FFFF, 1'b1, 32'h4ABC_FFFF, 1'b0, 2'd3, 1'b0, "R3 64KB");
        miss(32'h3002_0000, "R3 64KB boundary");
        look(32'h55AB_CDEF, 1'b1, 32'h66AB_CDEF, 1'b0, 2'd0, 1'b0, "R3 16MB");
        miss(32'h5500_1234, "R10 multi-hit");
        settle();
        rdchk(4'd8, 32'h11, "R10 multi cause");
        rdchk(4'd10, 32'h5500_1234, "R9 fault address on multi");

        // interrupt gating and clearing
        chk("R12 irq masked", {31'b0, irq}, 32'h0);
        wr(4'd9, 32'h10);
        chk("R12 irq on", {31'b0, irq}, 32'h1);
        wr(4'd8, 32'h10);
        chk("R12 irq off", {31'b0, irq}, 32'h0);
        rdchk(4'd8, 32'h01, "R11 zero bits kept");
        wr(4'd9, 32'h01);
        chk("R12 irq bit0", {31'b0, irq}, 32'h1);
        wr(4'd8, 32'h1F);
        chk("R12 irq cleared", {31'b0, irq}, 32'h0);
        rdchk(4'd8, 32'h0, "R11 all cleared");

        // single and global flush
        wr(4'd7, 32'h0040_0000);
        miss(32'h0040_0ABC, "R8 flushed entry");
        look(32'h100F_FFFC, 1'b1, 32'h200F_FFFC, 1'b0, 2'd1, 1'b0, "R8 other kept");
        wr(4'd6, 32'h0);
        miss(32'h100F_FFFC, "R7 flushed");
        look(32'h5500_1234, 1'b1, 32'h6600_1234, 1'b0, 2'd0, 1'b0, "R7 keep survives");
        settle();
        slotchk(3, 0, 32'h5500_000F, 32'h6612_3000, "R7 slot3 valid");

        // replacement pointer and lock floor
        wr(4'd3, 32'h79E0);
        put(32'hABC0_0002, 32'h1111_1000);
        rdchk(4'd3, 32'h79F0, "R6 ptr 31");
        put(32'hABC0_1002, 32'h2222_2000);
        rdchk(4'd3, 32'h79E0, "R6 wrap to floor");
        wr(4'd3, 32'h7820);
        put(32'hABC0_2002, 32'h3333_3000);
        rdchk(4'd3, 32'h79F0, "R6 below floor redirected");
        slotchk(2, 30, 32'h3001_0001, 32'h4ABC_0180, "R6 locked slot2 untouched");
        slotchk(30, 30, 32'hABC0_2006, 32'h3333_3000, "R6 slot30");
        miss(32'hABC0_0010, "R6 overwritten slot");
        look(32'hABC0_2010, 1'b1, 32'h3333_3010, 1'b0, 2'd0, 1'b0, "R6 new slot30");
        look(32'hABC0_1FFF, 1'b1, 32'h2222_2FFF, 1'b0, 2'd0, 1'b0, "R6 slot31");
        settle();
        chk("R4 all answers seen", 32'(sb.size()), 32'd0);

        summary();
    end

endmodule